// File: doc/BRIEF.md
# Windowed Bus Decoder with Select-Lane Translation

This block sits between one Wishbone initiator and a fixed group of subordinates. Each subordinate owns a window of the initiator's word-address space. The block is purely combinational. It raises cycle only toward the subordinate whose window holds the current address. It hands that subordinate an address relative to its window and routes the subordinate's handshake and read data back to the initiator. All window placement happens at elaboration time. Windows are placed one after another, each aligned to its own size, unless a subordinate is given a fixed base.

Two kinds of adaptation are done per subordinate. A *dense* subordinate has the full data width but may use a finer byte-select unit than the initiator. Each initiator select bit is then spread over `ratio` subordinate select bits, and the subordinate address is multiplied by that ratio. A *sparse* subordinate is narrower and has one select bit. It is wired to the lowest lane: it receives the low data bits and select bit 0, and its read data comes back zero-extended.

Back-pressure follows the bus protocol. The initiator's strobe is a request; the selected subordinate's stall holds it off and its ack completes it. The block adds no storage, so a response appears in the same cycle the subordinate gives it.

Top module: `wb_window_decoder`

## Requirements
- R1: A bit of `dn_cyc` is high only when `up_cyc` is high and the address lies in that subordinate's window. At most one bit is ever high.
- R2: `dn_stb`, `dn_we`, `dn_lock`, `dn_cti` and `dn_bte` equal their initiator inputs. A dense subordinate's write data equals `up_dat_w` unchanged.
- R3: For a dense subordinate whose select unit equals the initiator's, the subordinate address is `up_adr` minus the window base, truncated to the subordinate's address width.
- R4: `up_ack`, `up_err`, `up_rty`, `up_stall` and `up_dat_r` come only from the subordinate whose `dn_cyc` bit is high. A response that the subordinate is configured not to have reads as 0. With defaults, subordinate 0 has no err, rty or stall.
- R5: For a dense subordinate with finer select units (ratio r), subordinate select bit j equals initiator select bit j/r. With defaults, subordinate 1 has r = 2, so `up_sel` = 2'b01 gives 4'b0011 in its 4-bit slice. Select slice bits beyond the subordinate's own select width are 0.
- R6: For that finer-grained subordinate, the subordinate address is the window offset shifted left by log2(r), truncated to its address width.
- R7: A sparse subordinate (subordinate 2 by default, 16 bits wide) gets address = window offset unscaled, select = {000, `up_sel[0]`}, write data = low 16 bits of `up_dat_w` with the upper bits 0, and read data returned zero-extended.
- R8: While a sparse subordinate is selected and `up_sel[0]` is 0, `up_dat_r` is 0.
- R9: Windows without a fixed base are placed in index order, each aligned to its own size. A fixed base overrides placement and moves the cursor. Default map, in word addresses: subordinate 0 at 0x000–0x03F, subordinate 1 at a fixed base 0x100–0x11F, subordinate 2 at 0x120–0x13F.
- R10: When no window matches, or `up_cyc` is low, every `dn_cyc` bit is 0 and `up_ack`, `up_err`, `up_rty`, `up_stall` and `up_dat_r` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| up_cyc | input | 1 | Initiator bus cycle |
| up_stb | input | 1 | Initiator strobe |
| up_we | input | 1 | Initiator write enable |
| up_lock | input | 1 | Initiator lock |
| up_adr | input | ADDR_W | Initiator word address |
| up_sel | input | DATA_W/GRAN | Initiator select |
| up_dat_w | input | DATA_W | Initiator write data |
| up_cti | input | 3 | Cycle type |
| up_bte | input | 2 | Burst type |
| up_dat_r | output | DATA_W | Read data to initiator |
| up_ack | output | 1 | Ack to initiator |
| up_err | output | 1 | Error to initiator |
| up_rty | output | 1 | Retry to initiator |
| up_stall | output | 1 | Stall to initiator |
| dn_cyc | output | N_SUB | Per-subordinate bus cycle |
| dn_stb | output | 1 | Shared strobe |
| dn_we | output | 1 | Shared write enable |
| dn_lock | output | 1 | Shared lock |
| dn_cti | output | 3 | Shared cycle type |
| dn_bte | output | 2 | Shared burst type |
| dn_adr | output | N_SUB*ADDR_W | Per-subordinate translated address |
| dn_sel | output | N_SUB*(DATA_W/8) | Per-subordinate select |
| dn_dat_w | output | N_SUB*DATA_W | Per-subordinate write data |
| dn_dat_r | input | N_SUB*DATA_W | Per-subordinate read data |
| dn_ack | input | N_SUB | Per-subordinate ack |
| dn_err | input | N_SUB | Per-subordinate error |
| dn_rty | input | N_SUB | Per-subordinate retry |
| dn_stall | input | N_SUB | Per-subordinate stall |

## Verification
The bench drives the last and first word of every window and the words just outside them, including the gap between the placed and the fixed window. An off-by-one in the window compare or a wrong placement would raise the wrong cycle there, or none at all. It drives err, rty and stall high on the subordinate that lacks them. A missing mask would leak them to the initiator. It also checks select spreading and address scaling on the finer-grained subordinate, and the low-lane zeroing on the sparse one. Swapped select indices, an unscaled address or ungated sparse read data each change a visible port value.

// File: rtl/wbdec_pkg.sv
package wbdec_pkg;
  localparam int CTI_W = 3;
  localparam int BTE_W = 2;
  localparam int MIN_GRAN = 8;
  localparam logic [31:0] AUTO_BASE = 32'hFFFF_FFFF;

  typedef struct packed {
    logic ack;
    logic err;
    logic rty;
    logic stall;
  } wbdec_resp_t;
endpackage

// File: rtl/wbdec_window.sv
module wbdec_window #(
  parameter int ADDR_W = 16,
  parameter int BASE   = 0,
  parameter int SIZE   = 64,
  parameter int SHIFT  = 0,
  parameter int SUB_AW = 6
) (
  input  logic              cyc,
  input  logic [ADDR_W-1:0] adr,
  output logic              hit,
  output logic [ADDR_W-1:0] sub_adr
);
  localparam logic [31:0] BASE_L = 32'(BASE);
  localparam logic [31:0] SIZE_L = 32'(SIZE);
  localparam logic [31:0] MASK_L = (32'd1 << SUB_AW) - 32'd1;

  logic [31:0] a32;
  logic [31:0] off;
  logic [31:0] scaled;

  always_comb begin
    a32     = 32'(adr);
    off     = a32 - BASE_L;
    scaled  = (off << SHIFT) & MASK_L;
    hit     = cyc && (a32 >= BASE_L) && (off < SIZE_L);
    sub_adr = scaled[ADDR_W-1:0];
  end

  logic unused_scaled_hi;
  assign unused_scaled_hi = ^scaled[31:ADDR_W];
endmodule

// File: rtl/wbdec_lane_map.sv
module wbdec_lane_map #(
  parameter int DATA_W   = 32,
  parameter int GRAN     = 16,
  parameter int SUB_GRAN = 16,
  parameter bit SPARSE   = 1'b0
) (
  input  logic [DATA_W/GRAN-1:0] sel,
  input  logic [DATA_W-1:0]      dat_w,
  input  logic [DATA_W-1:0]      dat_r_dn,
  output logic [DATA_W/8-1:0]    sel_dn,
  output logic [DATA_W-1:0]      dat_w_dn,
  output logic [DATA_W-1:0]      dat_r_up
);
  localparam int RATIO = GRAN / SUB_GRAN;
  localparam int NSEL  = DATA_W / SUB_GRAN;

  generate
    if (SPARSE) begin : g_sparse
      always_comb begin
        sel_dn    = '0;
        sel_dn[0] = sel[0];
        dat_w_dn  = '0;
        dat_r_up  = '0;
        for (int b = 0; b < SUB_GRAN; b++) begin
          dat_w_dn[b] = dat_w[b];
          dat_r_up[b] = sel[0] & dat_r_dn[b];
        end
      end
      logic unused_sparse;
      assign unused_sparse = ^{sel, dat_w, dat_r_dn};
    end else begin : g_dense
      always_comb begin
        sel_dn = '0;
        for (int j = 0; j < NSEL; j++) begin
          sel_dn[j] = sel[j / RATIO];
        end
      end
      assign dat_w_dn = dat_w;
      assign dat_r_up = dat_r_dn;
    end
  endgenerate
endmodule

// File: rtl/wbdec_resp_mux.sv
module wbdec_resp_mux
  import wbdec_pkg::*;
#(
  parameter int N      = 3,
  parameter int DATA_W = 32
) (
  input  logic [N-1:0]        hit,
  input  logic [N*DATA_W-1:0] dat_in,
  input  logic [N*4-1:0]      resp_in,
  output logic [DATA_W-1:0]   dat_out,
  output wbdec_resp_t         resp_out
);
  always_comb begin
    dat_out  = '0;
    resp_out = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) begin
        dat_out  = dat_out | dat_in[i*DATA_W +: DATA_W];
        resp_out = resp_out | wbdec_resp_t'(resp_in[i*4 +: 4]);
      end
    end
  end
endmodule

// File: rtl/wb_window_decoder.sv
module wb_window_decoder
  import wbdec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int GRAN   = 16,
  parameter int N_SUB  = 3,
  parameter logic [N_SUB*32-1:0] SUB_AW     = {32'd5, 32'd6, 32'd6},
  parameter logic [N_SUB*32-1:0] SUB_GRAN   = {32'd16, 32'd8, 32'd16},
  parameter logic [N_SUB-1:0]    SUB_SPARSE = 3'b100,
  parameter logic [N_SUB*32-1:0] SUB_BASE   = {32'hFFFF_FFFF, 32'h0000_0100, 32'hFFFF_FFFF},
  parameter logic [N_SUB*3-1:0]  SUB_RESP   = {3'b111, 3'b111, 3'b000}
) (
  input  logic                    up_cyc,
  input  logic                    up_stb,
  input  logic                    up_we,
  input  logic                    up_lock,
  input  logic [ADDR_W-1:0]       up_adr,
  input  logic [DATA_W/GRAN-1:0]  up_sel,
  input  logic [DATA_W-1:0]       up_dat_w,
  input  logic [2:0]              up_cti,
  input  logic [1:0]              up_bte,
  output logic [DATA_W-1:0]       up_dat_r,
  output logic                    up_ack,
  output logic                    up_err,
  output logic                    up_rty,
  output logic                    up_stall,
  output logic [N_SUB-1:0]        dn_cyc,
  output logic                    dn_stb,
  output logic                    dn_we,
  output logic                    dn_lock,
  output logic [2:0]              dn_cti,
  output logic [1:0]              dn_bte,
  output logic [N_SUB*ADDR_W-1:0] dn_adr,
  output logic [N_SUB*(DATA_W/8)-1:0] dn_sel,
  output logic [N_SUB*DATA_W-1:0] dn_dat_w,
  input  logic [N_SUB*DATA_W-1:0] dn_dat_r,
  input  logic [N_SUB-1:0]        dn_ack,
  input  logic [N_SUB-1:0]        dn_err,
  input  logic [N_SUB-1:0]        dn_rty,
  input  logic [N_SUB-1:0]        dn_stall
);
  localparam int SELW  = DATA_W / GRAN;
  localparam int SSELW = DATA_W / MIN_GRAN;

  function automatic int shift_of(int k);
    int g;
    g = int'(SUB_GRAN[k*32 +: 32]);
    return SUB_SPARSE[k] ? 0 : $clog2(GRAN / g);
  endfunction

  function automatic int win_size(int k);
    int aw;
    aw = int'(SUB_AW[k*32 +: 32]);
    return (1 << aw) >> shift_of(k);
  endfunction

  function automatic int base_of(int idx);
    int cur;
    int b;
    int sz;
    cur = 0;
    b   = 0;
    for (int k = 0; k <= idx; k++) begin
      sz = win_size(k);
      if (SUB_BASE[k*32 +: 32] != AUTO_BASE) b = int'(SUB_BASE[k*32 +: 32]);
      else b = ((cur + sz - 1) / sz) * sz;
      cur = b + sz;
    end
    return b;
  endfunction

  logic [N_SUB*DATA_W-1:0] dat_up_flat;
  logic [N_SUB*4-1:0]      resp_flat;
  wbdec_resp_t             resp_sel;

  assign dn_stb  = up_stb;
  assign dn_we   = up_we;
  assign dn_lock = up_lock;
  assign dn_cti  = up_cti;
  assign dn_bte  = up_bte;

  generate
    for (genvar i = 0; i < N_SUB; i++) begin : g_sub
      localparam int          AW_I = int'(SUB_AW[i*32 +: 32]);
      localparam int          GR_I = int'(SUB_GRAN[i*32 +: 32]);
      localparam logic [2:0]  RM_I = SUB_RESP[i*3 +: 3];

      wbdec_window #(
        .ADDR_W(ADDR_W), .BASE(base_of(i)), .SIZE(win_size(i)),
        .SHIFT(shift_of(i)), .SUB_AW(AW_I)
      ) u_win (
        .cyc(up_cyc), .adr(up_adr),
        .hit(dn_cyc[i]), .sub_adr(dn_adr[i*ADDR_W +: ADDR_W])
      );

      wbdec_lane_map #(
        .DATA_W(DATA_W), .GRAN(GRAN), .SUB_GRAN(GR_I), .SPARSE(SUB_SPARSE[i])
      ) u_lane (
        .sel(up_sel), .dat_w(up_dat_w),
        .dat_r_dn(dn_dat_r[i*DATA_W +: DATA_W]),
        .sel_dn(dn_sel[i*SSELW +: SSELW]),
        .dat_w_dn(dn_dat_w[i*DATA_W +: DATA_W]),
        .dat_r_up(dat_up_flat[i*DATA_W +: DATA_W])
      );

      assign resp_flat[i*4 +: 4] = {dn_ack[i], dn_err[i] & RM_I[0],
                                    dn_rty[i] & RM_I[1], dn_stall[i] & RM_I[2]};
    end
  endgenerate

  wbdec_resp_mux #(.N(N_SUB), .DATA_W(DATA_W)) u_mux (
    .hit(dn_cyc), .dat_in(dat_up_flat), .resp_in(resp_flat),
    .dat_out(up_dat_r), .resp_out(resp_sel)
  );

  assign up_ack   = resp_sel.ack;
  assign up_err   = resp_sel.err;
  assign up_rty   = resp_sel.rty;
  assign up_stall = resp_sel.stall;

  logic unused_sel_w;
  assign unused_sel_w = ^SELW;
endmodule

// File: rtl/wbdec_checker.sv
module wbdec_checker #(
  parameter int DATA_W = 32,
  parameter int SELW   = 2,
  parameter int N_SUB  = 3,
  parameter logic [N_SUB-1:0] SPARSE = '0
) (
  input logic                    up_cyc,
  input logic [SELW-1:0]         up_sel,
  input logic [DATA_W-1:0]       up_dat_r,
  input logic                    up_ack,
  input logic                    up_err,
  input logic                    up_rty,
  input logic                    up_stall,
  input logic [N_SUB-1:0]        dn_cyc,
  input logic [N_SUB-1:0]        dn_ack
);
  always_comb begin
    AST_CYC_ONEHOT: assert ($onehot0(dn_cyc)); // R1
    if (!up_cyc) begin
      AST_CYC_NEEDS_INIT: assert (dn_cyc == '0); // R1
    end
    if (dn_cyc == '0) begin
      AST_UNMAPPED_QUIET: assert (!up_ack && !up_err && !up_rty && !up_stall && up_dat_r == '0); // R10
    end
    if (up_ack) begin
      AST_ACK_SOURCE: assert ((dn_cyc & dn_ack) != '0); // R4
    end
    for (int i = 0; i < N_SUB; i++) begin
      if (SPARSE[i] && dn_cyc[i] && !up_sel[0]) begin
        AST_SPARSE_LOW_OFF: assert (up_dat_r == '0); // R8
      end
    end
  end
endmodule

bind wb_window_decoder wbdec_checker #(
  .DATA_W(DATA_W), .SELW(DATA_W/GRAN), .N_SUB(N_SUB), .SPARSE(SUB_SPARSE)
) u_wbdec_chk (
  .up_cyc(up_cyc), .up_sel(up_sel), .up_dat_r(up_dat_r),
  .up_ack(up_ack), .up_err(up_err), .up_rty(up_rty), .up_stall(up_stall),
  .dn_cyc(dn_cyc), .dn_ack(dn_ack)
);

// File: tb/wb_window_decoder_test.sv
`timescale 1ns/1ps
module wb_window_decoder_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SW = 2;
  localparam int SSW = 4;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic up_cyc, up_stb, up_we, up_lock;
  logic [AW-1:0] up_adr;
  logic [SW-1:0] up_sel;
  logic [DW-1:0] up_dat_w;
  logic [2:0] up_cti;
  logic [1:0] up_bte;
  logic [DW-1:0] up_dat_r;
  logic up_ack, up_err, up_rty, up_stall;
  logic [N-1:0] dn_cyc;
  logic dn_stb, dn_we, dn_lock;
  logic [2:0] dn_cti;
  logic [1:0] dn_bte;
  logic [N*AW-1:0] dn_adr;
  logic [N*SSW-1:0] dn_sel;
  logic [N*DW-1:0] dn_dat_w;
  logic [N*DW-1:0] dn_dat_r;
  logic [N-1:0] dn_ack, dn_err, dn_rty, dn_stall;

  wb_window_decoder uut (
    .up_cyc(up_cyc), .up_stb(up_stb), .up_we(up_we), .up_lock(up_lock),
    .up_adr(up_adr), .up_sel(up_sel), .up_dat_w(up_dat_w),
    .up_cti(up_cti), .up_bte(up_bte), .up_dat_r(up_dat_r),
    .up_ack(up_ack), .up_err(up_err), .up_rty(up_rty), .up_stall(up_stall),
    .dn_cyc(dn_cyc), .dn_stb(dn_stb), .dn_we(dn_we), .dn_lock(dn_lock),
    .dn_cti(dn_cti), .dn_bte(dn_bte), .dn_adr(dn_adr), .dn_sel(dn_sel),
    .dn_dat_w(dn_dat_w), .dn_dat_r(dn_dat_r), .dn_ack(dn_ack),
    .dn_err(dn_err), .dn_rty(dn_rty), .dn_stall(dn_stall)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, logic [127:0] got, logic [127:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int exp_idx(logic [AW-1:0] a);
    if (a < 16'h040) return 0;
    if (a >= 16'h100 && a < 16'h120) return 1;
    if (a >= 16'h120 && a < 16'h140) return 2;
    return 3;
  endfunction

  task automatic check_all(string ctx);
    int idx;
    logic [N-1:0] e_cyc;
    logic [N*AW-1:0] e_adr;
    logic [N*SSW-1:0] e_sel;
    logic [N*DW-1:0] e_dw;
    logic [3:0] e_rsp;
    logic [DW-1:0] e_dr;
    logic [31:0] a32;
    a32 = 32'(up_adr);
    idx = up_cyc ? exp_idx(up_adr) : 3;
    e_cyc = '0;
    if (idx < 3) e_cyc[idx] = 1'b1;
    e_adr[0*AW +: AW] = AW'(a32 & 32'h3F);
    e_adr[1*AW +: AW] = AW'(((a32 - 32'h100) << 1) & 32'h3F);
    e_adr[2*AW +: AW] = AW'((a32 - 32'h120) & 32'h1F);
    e_sel[3:0]  = {2'b00, up_sel};
    e_sel[7:4]  = {up_sel[1], up_sel[1], up_sel[0], up_sel[0]};
    e_sel[11:8] = {3'b000, up_sel[0]};
    e_dw = {{16'h0, up_dat_w[15:0]}, up_dat_w, up_dat_w};
    e_rsp = '0;
    e_dr = '0;
    case (idx)
      0: begin e_rsp = {dn_ack[0], 3'b000}; e_dr = dn_dat_r[31:0]; end
      1: begin e_rsp = {dn_ack[1], dn_err[1], dn_rty[1], dn_stall[1]}; e_dr = dn_dat_r[63:32]; end
      2: begin
        e_rsp = {dn_ack[2], dn_err[2], dn_rty[2], dn_stall[2]};
        e_dr = up_sel[0] ? {16'h0, dn_dat_r[79:64]} : '0;
      end
      default: ;
    endcase
    chk({ctx, " R1 R9 R10 cyc"}, 128'(dn_cyc), 128'(e_cyc));
    chk({ctx, " R3 R6 R7 adr"}, 128'(dn_adr), 128'(e_adr));
    chk({ctx, " R5 R7 sel"}, 128'(dn_sel), 128'(e_sel));
    chk({ctx, " R2 shared"}, 128'({dn_stb, dn_we, dn_lock, dn_cti, dn_bte}),
        128'({up_stb, up_we, up_lock, up_cti, up_bte}));
    chk({ctx, " R2 R7 dat_w"}, 128'(dn_dat_w), 128'(e_dw));
    chk({ctx, " R4 R10 resp"}, 128'({up_ack, up_err, up_rty, up_stall}), 128'(e_rsp));
    chk({ctx, " R4 R8 dat_r"}, 128'(up_dat_r), 128'(e_dr));
  endtask

  task automatic rand_all();
    up_stb = 1'($urandom); up_we = 1'($urandom); up_lock = 1'($urandom);
    up_sel = 2'($urandom); up_dat_w = $urandom;
    up_cti = 3'($urandom); up_bte = 2'($urandom);
    dn_dat_r = {$urandom, $urandom, $urandom};
    dn_ack = 3'($urandom); dn_err = 3'($urandom);
    dn_rty = 3'($urandom); dn_stall = 3'($urandom);
  endtask

  task automatic apply_adr(logic [AW-1:0] a, logic c, string ctx);
    @(negedge clk);
    up_adr = a;
    up_cyc = c;
    #2;
    check_all(ctx);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    up_cyc = 0; up_stb = 0; up_we = 0; up_lock = 0; up_adr = '0; up_sel = '0;
    up_dat_w = '0; up_cti = '0; up_bte = '0;
    dn_dat_r = '0; dn_ack = '0; dn_err = '0; dn_rty = '0; dn_stall = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #2;
    check_all("idle");

    // R1: cyc low with a mapped address and live responses
    rand_all();
    dn_ack = '1;
    apply_adr(16'h0010, 1'b0, "R1 cyc-low");

    // R9 boundaries of each window and of the gaps
    rand_all();
    dn_ack = '1; dn_err = '1; dn_rty = '1; dn_stall = '1;
    apply_adr(16'h0000, 1'b1, "R9 lo0");
    apply_adr(16'h003F, 1'b1, "R9 hi0");
    apply_adr(16'h0040, 1'b1, "R9 R10 gap-lo");
    apply_adr(16'h00FF, 1'b1, "R9 R10 gap-hi");
    apply_adr(16'h0100, 1'b1, "R9 lo1");
    apply_adr(16'h011F, 1'b1, "R9 hi1");
    apply_adr(16'h0120, 1'b1, "R9 lo2");
    apply_adr(16'h013F, 1'b1, "R9 hi2");
    apply_adr(16'h0140, 1'b1, "R9 R10 past-end");
    apply_adr(16'hFFFF, 1'b1, "R10 top");

    // R4: subordinate 0 lacks err/rty/stall
    apply_adr(16'h0005, 1'b1, "R4 missing-opt");
    chk("R4 sub0 err/rty/stall masked", 128'({up_err, up_rty, up_stall}), 128'(0));

    // R5 / R6 explicit
    up_sel = 2'b01;
    apply_adr(16'h0108, 1'b1, "R5 R6 fine");
    chk("R5 sel 01 -> 0011", 128'(dn_sel[7:4]), 128'(4'b0011));
    chk("R6 adr offset 8 -> 0x10", 128'(dn_adr[1*AW +: AW]), 128'(16'h0010));

    // R7 / R8 sparse
    up_sel = 2'b10;
    dn_dat_r[95:64] = 32'hDEAD_BEEF;
    apply_adr(16'h0125, 1'b1, "R8 sparse-off");
    chk("R8 sparse sel0 low gives 0", 128'(up_dat_r), 128'(0));
    up_sel = 2'b01;
    apply_adr(16'h0125, 1'b1, "R7 sparse-on");
    chk("R7 sparse zero-ext", 128'(up_dat_r), 128'(32'h0000_BEEF));
    chk("R7 sparse adr", 128'(dn_adr[2*AW +: AW]), 128'(16'h0005));

    for (int v = 0; v < 400; v++) begin
      logic [AW-1:0] a;
      int pick;
      rand_all();
      pick = int'($urandom % 4);
      case (pick)
        0: a = AW'($urandom % 64);
        1: a = AW'(16'h100 + ($urandom % 32));
        2: a = AW'(16'h120 + ($urandom % 32));
        default: a = AW'($urandom);
      endcase
      apply_adr(a, ($urandom % 8) != 0, "rand");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule